// File: doc/BRIEF.md
# Serial Link Interrupt Aggregator

This block gathers interrupt requests for one end of a serial bridge and decides where they are serviced. Requests from local sources, from software writes and from interrupt packets received over the link all land in a 32-bit pending register. A mode input selects what happens to the pending bits next.

In local mode, pending bits move into a status register. That register drives an interrupt line and a priority encoder. Software clears status bits either with a write-ones-to-clear or by naming a vector number.

In forwarding mode, the pending bits are frozen into a payload word and handed to the packet transmitter. They leave the pending register only when the transmitter reports completion.

A small pointer register decides whether status carried by a received interrupt packet is merged into the pending register, merged into the status register, or dropped.

Top module: `link_irq_ctrl`

## Requirements
- R1: After reset, pending and status are zero, the transmitter is idle, the pointer selects the pending register, `irq_o` is 0 and `vector` reads 0x8000_0000.
- R2: Ones on `src_irq`, or in `wdata` with `wr_pend` high, set the matching pending bits at the next clock edge. Zeros have no effect.
- R3: With `local_mode`=0, the transmitter idle and pending nonzero, the next edge raises `tx_busy` and captures pending into `tx_payload`. The payload holds steady while `tx_busy` stays high.
- R4: A `tx_done` pulse while busy drops `tx_busy` and clears from pending exactly the bits in `tx_payload`. Bits set during the flight stay pending and go out in the next payload.
- R5: With `local_mode`=1 and the transmitter idle, every pending bit moves into status at the next edge and leaves pending.
- R6: `wr_stat` clears every status bit that is 1 in `wdata`.
- R7: `vector` returns the index of the lowest-numbered set status bit in bits [4:0], with bit 31 at 0. Bit 0 has the highest priority. With status zero, `vector` reads 0x8000_0000.
- R8: `wr_vec` clears the single status bit numbered by `wdata[4:0]`. The upper bits of `wdata` are ignored.
- R9: `wr_ptr` loads the pointer from `wdata[1:0]`. On `rx_valid`, `rx_status` is ORed into pending (pointer 0) or into status (pointer 1). It is discarded for pointer 2 or 3.
- R10: A bit both cleared and newly set in the same cycle ends up set. This holds for a status clear against a transfer, and for a transmit completion against a new pending set.
- R11: `irq_o` is 1 exactly when status is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| local_mode | input | 1 | 1: service locally, 0: forward over link |
| src_irq | input | 32 | Local interrupt sources, set pending |
| wdata | input | 32 | Software write data |
| wr_pend | input | 1 | Write-ones-to-set pending |
| wr_stat | input | 1 | Write-ones-to-clear status |
| wr_vec | input | 1 | Clear status bit by vector number |
| wr_ptr | input | 1 | Load pointer register |
| rx_valid | input | 1 | Received interrupt packet status valid |
| rx_status | input | 32 | Status from received packet |
| tx_done | input | 1 | Transmitter finished the current packet |
| tx_busy | output | 1 | Packet payload valid / in flight |
| tx_payload | output | 32 | Interrupt packet payload |
| pending | output | 32 | Pending register contents |
| status | output | 32 | Status register contents |
| vector | output | 32 | Priority vector read value |
| irq_o | output | 1 | Interrupt line |

## Verification
Two pairs of events can collide in one cycle, and each collision is provoked on purpose.

In the first, software clears a status bit while the same bit is being moved in from pending. The bench loads status, writes the bit to pending, and then issues the clear on the very edge that does the transfer. It expects the bit to remain set.

In the second, a completed transmission lands in the same cycle as a fresh set of one of the bits just sent. The bench expects that bit to stay pending and to appear in the following payload, while the other sent bits clear.

// File: rtl/link_irq_ctrl.sv
module link_irq_ctrl #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         local_mode,
  input  logic [W-1:0] src_irq,
  input  logic [31:0]  wdata,
  input  logic         wr_pend,
  input  logic         wr_stat,
  input  logic         wr_vec,
  input  logic         wr_ptr,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_status,
  input  logic         tx_done,
  output logic         tx_busy,
  output logic [W-1:0] tx_payload,
  output logic [W-1:0] pending,
  output logic [W-1:0] status,
  output logic [31:0]  vector,
  output logic         irq_o
);
  localparam int VW = $clog2(W);
  localparam logic [1:0] PTR_PEND = 2'd0;
  localparam logic [1:0] PTR_STAT = 2'd1;

  logic [1:0]    ptr_q;
  logic [W-1:0]  pend_q, stat_q, sent_q;
  logic          busy_q;
  logic [VW-1:0] idx;

  wire [W-1:0] rx_pend = (rx_valid && ptr_q == PTR_PEND) ? rx_status : '0;
  wire [W-1:0] rx_stat = (rx_valid && ptr_q == PTR_STAT) ? rx_status : '0;
  wire [W-1:0] set_p   = src_irq | (wr_pend ? wdata[W-1:0] : '0) | rx_pend;
  wire         launch  = !local_mode && !busy_q && (|pend_q);
  wire         done    = busy_q && tx_done;
  wire [W-1:0] xfer    = (local_mode && !busy_q) ? pend_q : '0;
  wire [W-1:0] vclr    = wr_vec ? (W'(1) << wdata[VW-1:0]) : '0;
  wire [W-1:0] clr_s   = (wr_stat ? wdata[W-1:0] : '0) | vclr;
  wire [W-1:0] sent_c  = done ? sent_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= PTR_PEND;
      pend_q <= '0;
      stat_q <= '0;
      sent_q <= '0;
      busy_q <= 1'b0;
    end else begin
      if (wr_ptr) ptr_q <= wdata[1:0];
      pend_q <= (pend_q & ~xfer & ~sent_c) | set_p;
      stat_q <= (stat_q & ~clr_s) | xfer | rx_stat;
      if (launch) begin
        sent_q <= pend_q;
        busy_q <= 1'b1;
      end else if (done) begin
        busy_q <= 1'b0;
      end
    end
  end

  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--)
      if (stat_q[i]) idx = VW'(i);
  end

  assign vector     = (|stat_q) ? {{(32-VW){1'b0}}, idx} : 32'h8000_0000;
  assign irq_o      = |stat_q;
  assign tx_busy    = busy_q;
  assign tx_payload = sent_q;
  assign pending    = pend_q;
  assign status     = stat_q;
endmodule

// File: rtl/link_irq_ctrl_chk.sv
module link_irq_ctrl_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         local_mode,
  input logic         tx_done,
  input logic         tx_busy,
  input logic [W-1:0] tx_payload,
  input logic [W-1:0] pending,
  input logic [W-1:0] status,
  input logic [31:0]  vector,
  input logic         irq_o
);
  localparam int VW = $clog2(W);

  // R3
  launch_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!local_mode && !tx_busy && pending != '0) |=> (tx_busy && tx_payload == $past(pending)));

  // R3
  payload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !tx_done) |=> (tx_busy && $stable(tx_payload)));

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && tx_done) |=> !tx_busy);

  // R5
  local_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (local_mode && !tx_busy) |=> ((status & $past(pending)) == $past(pending)));

  // R7
  empty_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> (vector == 32'h8000_0000));

  // R7
  lowest_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status != '0) |-> (!vector[31] && status[vector[VW-1:0]] &&
      ((status & ((W'(1) << vector[VW-1:0]) - W'(1))) == '0)));

  // R11
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> !vector[31]);
endmodule

bind link_irq_ctrl link_irq_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .local_mode(local_mode), .tx_done(tx_done),
  .tx_busy(tx_busy), .tx_payload(tx_payload), .pending(pending),
  .status(status), .vector(vector), .irq_o(irq_o)
);

// File: tb/test_link_irq_ctrl.sv
module test_link_irq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic local_mode = 1'b0, wr_pend = 1'b0, wr_stat = 1'b0, wr_vec = 1'b0, wr_ptr = 1'b0;
  logic rx_valid = 1'b0, tx_done = 1'b0;
  logic [31:0] src_irq = '0, wdata = '0, rx_status = '0;
  logic tx_busy, irq_o;
  logic [31:0] tx_payload, pending, status, vector;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  link_irq_ctrl i_link_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .local_mode(local_mode), .src_irq(src_irq),
    .wdata(wdata), .wr_pend(wr_pend), .wr_stat(wr_stat), .wr_vec(wr_vec),
    .wr_ptr(wr_ptr), .rx_valid(rx_valid), .rx_status(rx_status), .tx_done(tx_done),
    .tx_busy(tx_busy), .tx_payload(tx_payload), .pending(pending),
    .status(status), .vector(vector), .irq_o(irq_o)
  );

  // {status value loaded, expected vector}
  localparam logic [63:0] VEC_TAB [6] = '{
    {32'h0000_0001, 32'd0},  {32'h8000_0000, 32'd31},
    {32'h00F0_0000, 32'd20}, {32'h8000_0100, 32'd8},
    {32'hFFFF_FFFF, 32'd0},  {32'h0000_0006, 32'd1}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    wr_pend = 0; wr_stat = 0; wr_vec = 0; wr_ptr = 0;
    rx_valid = 0; tx_done = 0; src_irq = '0;
  endtask

  task automatic load_stat(logic [31:0] v);
    local_mode = 1; wr_pend = 1; wdata = v;
    cyc();
    cyc();
  endtask

  task automatic wipe();
    wr_stat = 1; wdata = '1;
    cyc();
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 pending", pending, 0);
    chk("R1 status", status, 0);
    chk("R1 busy", {31'b0, tx_busy}, 0);
    chk("R1 vector", vector, 32'h8000_0000);
    chk("R1 irq", {31'b0, irq_o}, 0);
    rst_n = 1;
    @(negedge clk);

    // R7 R11 R5 table walk
    for (int k = 0; k < 6; k++) begin
      load_stat(VEC_TAB[k][63:32]);
      chk("R5 status", status, VEC_TAB[k][63:32]);
      chk("R5 pending", pending, 0);
      chk("R7 vector", vector, VEC_TAB[k][31:0]);
      chk("R11 irq", {31'b0, irq_o}, 1);
      wipe();
      chk("R6 cleared", status, 0);
      chk("R11 irq low", {31'b0, irq_o}, 0);
      chk("R7 empty", vector, 32'h8000_0000);
    end

    // R8 vector clear, upper bits ignored
    load_stat(32'h30);
    wr_vec = 1; wdata = 32'hFFFF_FFE4;
    cyc();
    chk("R8 clear by vector", status, 32'h20);
    chk("R8 vector", vector, 32'd5);
    // R6 partial clear
    wr_stat = 1; wdata = 32'h0000_0010;
    cyc();
    chk("R6 untouched", status, 32'h20);
    wr_stat = 1; wdata = 32'h20;
    cyc();
    chk("R6 clear", status, 0);

    // R10 clear vs transfer of the same bit
    load_stat(32'h8);
    wr_pend = 1; wdata = 32'h8;
    cyc();
    wr_stat = 1; wdata = 32'h8;
    cyc();
    chk("R10 set beats clear", status, 32'h8);
    wipe();
    chk("R10 control clear", status, 0);

    // R2 R3 R4 R10 forwarding
    local_mode = 0;
    wr_pend = 1; wdata = 32'h11;
    cyc();
    chk("R2 pending set", pending, 32'h11);
    chk("R3 not yet busy", {31'b0, tx_busy}, 0);
    cyc();
    chk("R3 busy", {31'b0, tx_busy}, 1);
    chk("R3 payload", tx_payload, 32'h11);
    src_irq = 32'h100;
    cyc();
    chk("R2 src set", pending, 32'h111);
    chk("R3 payload hold", tx_payload, 32'h11);
    tx_done = 1; src_irq = 32'h1;
    cyc();
    chk("R4 R10 pending after done", pending, 32'h101);
    chk("R4 idle", {31'b0, tx_busy}, 0);
    cyc();
    chk("R4 next payload", tx_payload, 32'h101);
    chk("R5 forward leaves status", status, 0);
    tx_done = 1;
    cyc();
    chk("R4 drained", pending, 0);

    // R9 pointer routing
    rx_valid = 1; rx_status = 32'h5;
    cyc();
    chk("R9 ptr0 to pending", pending, 32'h5);
    cyc();
    tx_done = 1;
    cyc();
    wr_ptr = 1; wdata = 32'hFFFF_FFF1;
    cyc();
    rx_valid = 1; rx_status = 32'h30;
    cyc();
    chk("R9 ptr1 to status", status, 32'h30);
    chk("R9 ptr1 pending", pending, 0);
    wr_ptr = 1; wdata = 32'h2;
    cyc();
    rx_valid = 1; rx_status = 32'hF00;
    cyc();
    chk("R9 ptr2 status", status, 32'h30);
    chk("R9 ptr2 pending", pending, 0);
    wipe();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule